// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Router

This block sits behind a CAN receiver and decides, for every correctly received frame, where that frame is stored. There are three possible outcomes. The frame can go to the receive FIFO, or to a single-message high-priority receive buffer, or it can be dropped. The block has up to two FIFO acceptance filters and one dedicated priority filter. Each filter is a pair of identifier and mask registers written by the CPU.

Each filter compares the incoming identifier with its programmed identifier, but only on bit positions where the mask bit is 1. Extended frames are compared over all 29 identifier bits. Standard frames carry their 11-bit identifier in the top bits of the identifier port and are compared over those 11 bits only. A parameter sets the number of FIFO filters to 0, 1 or 2. With no FIFO filters, every frame is accepted for the FIFO. The priority path is a build option. When a frame matches the priority filter and the priority buffer has room, the buffer takes the frame ahead of the FIFO.

A frame whose destination is full is lost. When that happens, a sticky overrun flag is set for that destination. Software clears the flags through the same write port it uses for the filters.

Top module: `can_rx_router`

## Requirements
- R1: After reset, both write strobes and both overrun flags are 0. Every filter resets to identifier 0 with an all-ones mask.
- R2: A filter matches when the incoming identifier equals the filter identifier on every bit position where the filter mask is 1. Positions where the mask is 0 are ignored.
- R3: For a standard frame (`frm_ext`=0), only identifier bits 28:18 take part in the match. Bits 17:0 are ignored, whatever the mask holds in those positions.
- R4: A frame accepted for the FIFO produces a one-cycle `fifo_wr` pulse in the clock cycle after `frm_valid`. In that same cycle, `out_ext`, `out_id`, `out_dlc` and `out_data` hold the frame's fields.
- R5: A frame that matches no filter causes no write and sets no overrun flag.
- R6: With two FIFO filters, a frame that matches either filter is accepted for the FIFO.
- R7: With `NUM_FILT`=0, every received frame is written to the FIFO.
- R8: A frame that matches the priority filter while `prio_full` is 0 is written only to the priority buffer, with a `prio_wr` pulse one cycle after `frm_valid`. This holds even when the frame also matches a FIFO filter.
- R9: A frame that matches the priority filter while `prio_full` is 1, and also matches a FIFO filter, goes to the FIFO.
- R10: A frame whose chosen destination is full is not written. The destination's overrun flag is set and stays set until a configuration write to address 6. In that write, `cfg_wdata` bit 0 clears `fifo_ovr` and bit 1 clears `prio_ovr`.
- R11: With `PRIO_EN`=0, `prio_wr` never asserts.
- R12: Configuration addresses are as follows: 0 and 1 are filter 0's identifier and mask, 2 and 3 are filter 1's identifier and mask, 4 and 5 are the priority filter's identifier and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe for a correctly received frame |
| frm_ext | input | 1 | 1 = extended (29-bit) identifier, 0 = standard |
| frm_id | input | 29 | Identifier; a standard identifier occupies bits 28:18 |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Payload |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 29 | Configuration write data |
| fifo_full | input | 1 | Receive FIFO cannot take a frame |
| prio_full | input | 1 | Priority buffer is occupied |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| prio_wr | output | 1 | Write strobe to the priority buffer |
| out_ext | output | 1 | Frame format for the write |
| out_id | output | 29 | Identifier for the write |
| out_dlc | output | 4 | Data length code for the write |
| out_data | output | 64 | Payload for the write |
| fifo_ovr | output | 1 | Sticky: a FIFO-bound frame was lost |
| prio_ovr | output | 1 | Sticky: a priority-bound frame was lost |

## Verification
The bench programs a standard frame whose low identifier bits differ from a filter that cares about those bits. A design that widened the standard compare would drop a frame that should be accepted. It sends frames that match both the priority filter and a FIFO filter, once with the buffer free and once with it occupied. Wrong precedence shows up as a write to the wrong port, or as a lost frame. It fills both destinations and clears the overrun flags one at a time, so a design that wrote to a full destination, let a flag decay on its own, or cleared both flags with one bit would be caught. A second instance with no FIFO filters and no priority path must accept everything into the FIFO.

// File: rtl/can_rx_router.sv
module can_rx_router #(
  parameter int NUM_FILT = 2,
  parameter int PRIO_EN  = 1,
  parameter int IW       = 29,
  parameter int STD_W    = 11,
  parameter int DATA_W   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic              frm_ext,
  input  logic [IW-1:0]     frm_id,
  input  logic [3:0]        frm_dlc,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [IW-1:0]     cfg_wdata,
  input  logic              fifo_full,
  input  logic              prio_full,
  output logic              fifo_wr,
  output logic              prio_wr,
  output logic              out_ext,
  output logic [IW-1:0]     out_id,
  output logic [3:0]        out_dlc,
  output logic [DATA_W-1:0] out_data,
  output logic              fifo_ovr,
  output logic              prio_ovr
);
  localparam int NF = (NUM_FILT == 0) ? 1 : NUM_FILT;
  localparam logic [IW-1:0] STD_CMP = {{STD_W{1'b1}}, {(IW-STD_W){1'b0}}};
  localparam logic [2:0] A_PID = 3'd4, A_PMSK = 3'd5, A_CLR = 3'd6;

  logic [IW-1:0] f_id [NF];
  logic [IW-1:0] f_msk [NF];
  logic [IW-1:0] p_id, p_msk;
  logic [NF-1:0] f_hit;

  wire [IW-1:0] cmp = frm_ext ? {IW{1'b1}} : STD_CMP;

  for (genvar g = 0; g < NF; g++) begin : g_filt
    always_ff @(posedge clk) begin
      if (rst) begin
        f_id[g]  <= '0;
        f_msk[g] <= '1;
      end else if (cfg_we && g < NUM_FILT) begin
        if (cfg_addr == 3'(2*g))   f_id[g]  <= cfg_wdata;
        if (cfg_addr == 3'(2*g+1)) f_msk[g] <= cfg_wdata;
      end
    end
    assign f_hit[g] = ((frm_id ^ f_id[g]) & f_msk[g] & cmp) == '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_id  <= '0;
      p_msk <= '1;
    end else if (cfg_we) begin
      if (cfg_addr == A_PID)  p_id  <= cfg_wdata;
      if (cfg_addr == A_PMSK) p_msk <= cfg_wdata;
    end
  end

  wire fifo_hit = (NUM_FILT == 0) ? 1'b1 : |f_hit;
  wire p_hit    = (PRIO_EN != 0) && (((frm_id ^ p_id) & p_msk & cmp) == '0);
  wire to_p     = p_hit && !prio_full;
  wire to_f     = !to_p && fifo_hit && !fifo_full;
  wire lose_f   = !to_p && fifo_hit && fifo_full;
  wire lose_p   = p_hit && prio_full && !fifo_hit;
  wire clr      = cfg_we && cfg_addr == A_CLR;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr  <= 1'b0;
      prio_wr  <= 1'b0;
      fifo_ovr <= 1'b0;
      prio_ovr <= 1'b0;
    end else begin
      fifo_wr  <= frm_valid && to_f;
      prio_wr  <= frm_valid && to_p;
      fifo_ovr <= (fifo_ovr && !(clr && cfg_wdata[0])) || (frm_valid && lose_f);
      prio_ovr <= (prio_ovr && !(clr && cfg_wdata[1])) || (frm_valid && lose_p);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_ext  <= 1'b0;
      out_id   <= '0;
      out_dlc  <= '0;
      out_data <= '0;
    end else if (frm_valid) begin
      out_ext  <= frm_ext;
      out_id   <= frm_id;
      out_dlc  <= frm_dlc;
      out_data <= frm_data;
    end
  end
endmodule

module can_rx_router_chk #(
  parameter int PRIO_EN = 1,
  parameter int IW      = 29
) (
  input logic          clk,
  input logic          rst,
  input logic          frm_valid,
  input logic          fifo_full,
  input logic          prio_full,
  input logic          fifo_wr,
  input logic          prio_wr,
  input logic          fifo_ovr,
  input logic          prio_ovr,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic [IW-1:0] cfg_wdata
);
  wire clr_f = cfg_we && cfg_addr == 3'd6 && cfg_wdata[0];
  wire clr_p = cfg_we && cfg_addr == 3'd6 && cfg_wdata[1];

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst) !(fifo_wr && prio_wr)); // R8
  AST_WR_AFTER_VALID: assert property (@(posedge clk) disable iff (rst) (fifo_wr || prio_wr) |-> $past(frm_valid)); // R4
  AST_FIFO_NOT_FULL: assert property (@(posedge clk) disable iff (rst) fifo_wr |-> $past(!fifo_full)); // R10
  AST_PRIO_NOT_FULL: assert property (@(posedge clk) disable iff (rst) prio_wr |-> $past(!prio_full)); // R10
  AST_FOVR_STICKY: assert property (@(posedge clk) disable iff (rst) (fifo_ovr && !clr_f) |=> fifo_ovr); // R10
  AST_POVR_STICKY: assert property (@(posedge clk) disable iff (rst) (prio_ovr && !clr_p) |=> prio_ovr); // R10
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst) ($rose(fifo_ovr) || $rose(prio_ovr)) |-> $past(frm_valid)); // R10
  AST_NO_PRIO_PATH: assert property (@(posedge clk) disable iff (rst) (PRIO_EN == 0) |-> !prio_wr); // R11
endmodule

bind can_rx_router can_rx_router_chk #(.PRIO_EN(PRIO_EN), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .fifo_full(fifo_full),
  .prio_full(prio_full), .fifo_wr(fifo_wr), .prio_wr(prio_wr),
  .fifo_ovr(fifo_ovr), .prio_ovr(prio_ovr), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
);

// File: tb/sim_can_rx_router.sv
module sim_can_rx_router;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic frm_valid = 0, frm_ext = 0;
  logic [28:0] frm_id = '0;
  logic [3:0] frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = '0;
  logic [28:0] cfg_wdata = '0;
  logic fifo_full = 0, prio_full = 0;

  logic fifo_wr, prio_wr, out_ext, fifo_ovr, prio_ovr;
  logic [28:0] out_id;
  logic [3:0] out_dlc;
  logic [63:0] out_data;
  logic f1_wr, p1_wr, x1_ext, x1_fovr, x1_povr;
  logic [28:0] x1_id;
  logic [3:0] x1_dlc;
  logic [63:0] x1_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  can_rx_router u0 (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_id(frm_id),
    .frm_dlc(frm_dlc), .frm_data(frm_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fifo_full(fifo_full), .prio_full(prio_full),
    .fifo_wr(fifo_wr), .prio_wr(prio_wr), .out_ext(out_ext), .out_id(out_id),
    .out_dlc(out_dlc), .out_data(out_data), .fifo_ovr(fifo_ovr), .prio_ovr(prio_ovr));

  can_rx_router #(.NUM_FILT(0), .PRIO_EN(0)) u1 (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ext(frm_ext), .frm_id(frm_id),
    .frm_dlc(frm_dlc), .frm_data(frm_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fifo_full(1'b0), .prio_full(1'b0),
    .fifo_wr(f1_wr), .prio_wr(p1_wr), .out_ext(x1_ext), .out_id(x1_id),
    .out_dlc(x1_dlc), .out_data(x1_data), .fifo_ovr(x1_fovr), .prio_ovr(x1_povr));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [28:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input logic ext, input logic [28:0] id, input logic [63:0] d);
    @(negedge clk); frm_valid = 1; frm_ext = ext; frm_id = id; frm_data = d; frm_dlc = 4'd8;
    @(negedge clk); frm_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 fifo_wr", fifo_wr, 0);
    chk("R1 prio_wr", prio_wr, 0);
    chk("R1 fifo_ovr", fifo_ovr, 0);
    chk("R1 prio_ovr", prio_ovr, 0);
  endtask

  task automatic t_setup;
    cfg(3'd0, {11'h123, 18'h0});
    cfg(3'd1, {11'h7FF, 18'h0});
    cfg(3'd2, 29'h1ABCDE00);
    cfg(3'd3, 29'h1FFFFF00);
    cfg(3'd4, {11'h055, 18'h0});
    cfg(3'd5, {11'h7F0, 18'h0});
  endtask

  task automatic t_std_match;
    send(0, {11'h123, 18'h2AAAA}, 64'hDEADBEEF_01234567);
    chk("R4 fifo_wr", fifo_wr, 1);
    chk("R4 prio_wr", prio_wr, 0);
    chk("R4 out_id", out_id, {11'h123, 18'h2AAAA});
    chk("R4 out_data", out_data, 64'hDEADBEEF_01234567);
    chk("R4 out_dlc", out_dlc, 8);
    chk("R4 out_ext", out_ext, 0);
    @(negedge clk);
    chk("R4 pulse ends", fifo_wr, 0);
  endtask

  task automatic t_std_miss;
    send(0, {11'h124, 18'h0}, 64'h1);
    chk("R5 fifo_wr", fifo_wr, 0);
    chk("R5 prio_wr", prio_wr, 0);
    chk("R5 fifo_ovr", fifo_ovr, 0);
    chk("R7 u1 accepts all", f1_wr, 1);
  endtask

  task automatic t_std_low_bits;
    send(0, {11'h6AF, 18'h3FFFF}, 64'h2);
    chk("R3 std low bits ignored", fifo_wr, 1);
  endtask

  task automatic t_ext;
    send(1, 29'h1ABCDE7F, 64'h3);
    chk("R6 second filter hit", fifo_wr, 1);
    chk("R2 out_ext", out_ext, 1);
    send(1, 29'h1ABCDF00, 64'h4);
    chk("R2 masked bit differs", fifo_wr, 0);
    send(1, {11'h123, 18'h1F0F0}, 64'h5);
    chk("R2 unmasked low bits", fifo_wr, 1);
  endtask

  task automatic t_prio;
    send(0, {11'h05A, 18'h0}, 64'h6);
    chk("R8 prio_wr", prio_wr, 1);
    chk("R8 fifo_wr", fifo_wr, 0);
    chk("R11 u1 prio_wr", p1_wr, 0);
    chk("R7 u1 fifo_wr", f1_wr, 1);
  endtask

  task automatic t_prio_full;
    prio_full = 1;
    send(0, {11'h05A, 18'h0}, 64'h7);
    chk("R10 prio full no write", prio_wr, 0);
    chk("R10 prio full fifo_wr", fifo_wr, 0);
    chk("R10 prio_ovr set", prio_ovr, 1);
    chk("R10 fifo_ovr clear", fifo_ovr, 0);
    cfg(3'd0, {11'h050, 18'h0});
    cfg(3'd1, {11'h7F0, 18'h0});
    send(0, {11'h05A, 18'h0}, 64'h8);
    chk("R9 overflow to fifo", fifo_wr, 1);
    chk("R9 no prio", prio_wr, 0);
    prio_full = 0;
    send(0, {11'h05A, 18'h0}, 64'h9);
    chk("R8 both match prio wins", prio_wr, 1);
    chk("R8 both match no fifo", fifo_wr, 0);
  endtask

  task automatic t_fifo_full;
    fifo_full = 1; prio_full = 1;
    send(0, {11'h05A, 18'h0}, 64'hA);
    chk("R10 fifo full no write", fifo_wr, 0);
    chk("R10 fifo_ovr set", fifo_ovr, 1);
    fifo_full = 0; prio_full = 0;
    repeat (3) @(negedge clk);
    chk("R10 fifo_ovr sticky", fifo_ovr, 1);
    cfg(3'd6, 29'h1);
    chk("R10 fifo_ovr cleared", fifo_ovr, 0);
    chk("R10 prio_ovr kept", prio_ovr, 1);
    cfg(3'd6, 29'h2);
    chk("R10 prio_ovr cleared", prio_ovr, 0);
  endtask

  task automatic t_unused_addr;
    cfg(3'd7, 29'h0);
    send(0, {11'h05A, 18'h0}, 64'hB);
    chk("R12 prio filter unchanged", prio_wr, 1);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_setup;
    t_std_match;
    t_std_miss;
    t_std_low_bits;
    t_ext;
    t_prio;
    t_prio_full;
    t_fifo_full;
    t_unused_addr;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule